// File: doc/BRIEF.md
# No-Operation Sequence Length Decoder

This block watches an instruction byte stream that arrives one byte per cycle over a valid/ready handshake. It decides whether the bytes form a single no-operation instruction, in either the one-byte form (0x90) or the multi-byte form (0x0F 0x1F followed by a memory-operand descriptor byte). When the instruction ends, it reports the total length in bytes, whether the bytes were a no-operation, and whether an undefined-opcode fault applies. A decoder stage ahead of the execution units can use it to skip padding sequences of any recommended length in one step.

Before the opcode, up to one operand-size prefix (0x66) and one lock prefix (0xF0) are accepted, in either order. The descriptor byte is split into mode (bits 7:6), reg (bits 5:3) and r/m (bits 2:0). The mode and r/m fields decide how many index and displacement bytes follow. A configuration input states whether the multi-byte form exists; when it does not, that form ends in a fault.

Top module: `nop_len_decoder`

## Requirements
- R1: A synchronous active-high reset leaves res_valid at 0 and in_ready at 1, with no partial instruction held.
- R2: A byte is taken on a rising edge where in_valid and in_ready are both 1. On the edge that takes the final byte, the result registers load, so in the next cycle res_valid is 1 for exactly one cycle and in_ready is 0. Byte 0x90 alone gives res_is_nop=1, res_fault=0, res_len=1.
- R3: Each accepted 0x66 prefix adds one byte to the reported length. For example, 66 90 gives a no-operation of length 2.
- R4: For the multi-byte form 0F 1F with reg field 0, the descriptor bytes 0x00, 0x40, 0x44, 0x80 and 0x84 give total lengths 3, 4, 5, 7 and 8. With a 0x66 prefix the lengths are 6 for 0x44 and 9 for 0x84.
- R5: Trailing bytes follow general descriptor rules. r/m=100 with mode≠11 adds one index byte. Mode 01 adds 1 displacement byte. Mode 10 adds 4. Mode 00 with r/m=101 adds 4. Mode 11 adds nothing. So C0 gives 3, 05 gives 7, 04 gives 4 and 41 gives 4.
- R6: A descriptor byte with a nonzero reg field ends decoding at that byte with res_is_nop=0 and res_fault=0. The length counts the bytes consumed so far.
- R7: After the prefixes, a first byte other than 0x90, 0x0F, 0x66 or 0xF0 ends decoding at once as not-NOP without a fault. So does a byte other than 0x1F after 0x0F. The length counts the bytes consumed so far.
- R8: A lock prefix (0xF0) before a recognised no-operation makes the result a fault with res_is_nop=0. The length still covers the full instruction, up to 10 bytes (F0 66 0F 1F 84 plus five bytes).
- R9: When multibyte_en is 0, a 0x1F byte following 0x0F ends decoding at that byte with res_fault=1 and res_is_nop=0. The one-byte form is not affected.
- R10: A second copy of a prefix already seen in the same instruction ends decoding as not-NOP without a fault. The length counts the bytes consumed so far.
- R11: Cycles with in_valid low consume nothing and do not change the result. The same bytes spread over idle cycles give the same result as bytes sent back to back.
- R12: In the cycle after the result pulse, in_ready is 1 again, and the next byte starts a fresh instruction with no prefix state carried over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| multibyte_en | input | 1 | 1 when the multi-byte no-operation form is supported |
| in_valid | input | 1 | A byte is offered on in_data |
| in_data | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| res_valid | output | 1 | One-cycle result pulse |
| res_is_nop | output | 1 | The instruction was a valid no-operation |
| res_fault | output | 1 | An undefined-opcode fault applies |
| res_len | output | 4 | Bytes consumed by the instruction |

## Verification
Every recommended padding length from 1 to 9 is sent. These cases separate the prefix-count term from the descriptor-driven trailing count. Further descriptor bytes (register form, absolute 32-bit displacement, index byte without displacement) separate the mode rules from the r/m rules. Early-exit patterns (nonzero reg, foreign opcode, bad second opcode byte, repeated prefix) show that the length counts only consumed bytes. Lock-prefixed and unsupported-form cases tell the two fault sources apart, and spaced-out byte delivery shows that idle cycles do not disturb the count.

// File: rtl/nop_pkg.sv
package nop_pkg;
  localparam int LEN_W   = 4;
  localparam int TAIL_W  = 3;
  localparam int MAX_LEN = 10;

  localparam logic [7:0] B_OPSZ = 8'h66;
  localparam logic [7:0] B_LOCK = 8'hF0;
  localparam logic [7:0] B_NOP1 = 8'h90;
  localparam logic [7:0] B_ESC  = 8'h0F;
  localparam logic [7:0] B_MNOP = 8'h1F;

  typedef enum logic [2:0] {
    S_PFX, S_ESC, S_MODRM, S_TAIL, S_DONE
  } dec_state_t;

  // bytes that trail a descriptor byte: index byte plus displacement
  function automatic logic [TAIL_W-1:0] trail_count(input logic [7:0] d);
    logic [1:0] md;
    logic [2:0] rm;
    logic [TAIL_W-1:0] n;
    md = d[7:6];
    rm = d[2:0];
    n  = '0;
    if (md != 2'b11 && rm == 3'b100) n = n + 1'b1;
    if (md == 2'b01) n = n + 3'd1;
    else if (md == 2'b10) n = n + 3'd4;
    else if (md == 2'b00 && rm == 3'b101) n = n + 3'd4;
    return n;
  endfunction
endpackage

// File: rtl/nop_byte_class.sv
module nop_byte_class
  import nop_pkg::*;
(
  input  logic [7:0] byte_in,
  output logic       is_opsz,
  output logic       is_lock,
  output logic       is_nop1,
  output logic       is_esc,
  output logic       is_mnop
);
  assign is_opsz = (byte_in == B_OPSZ);
  assign is_lock = (byte_in == B_LOCK);
  assign is_nop1 = (byte_in == B_NOP1);
  assign is_esc  = (byte_in == B_ESC);
  assign is_mnop = (byte_in == B_MNOP);
endmodule

// File: rtl/nop_desc_decode.sv
module nop_desc_decode
  import nop_pkg::*;
(
  input  logic [7:0]        desc,
  output logic              reg_zero,
  output logic [TAIL_W-1:0] tail
);
  assign reg_zero = (desc[5:3] == 3'b000);
  assign tail     = trail_count(desc);
endmodule

// File: rtl/nop_len_decoder.sv
module nop_len_decoder
  import nop_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             multibyte_en,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             res_valid,
  output logic             res_is_nop,
  output logic             res_fault,
  output logic [LEN_W-1:0] res_len
);
  dec_state_t        state, nxt_state;
  logic [LEN_W-1:0]  cnt;
  logic [LEN_W-1:0]  cnt_inc;
  logic [TAIL_W-1:0] remain;
  logic              opsz_seen, lock_seen;

  logic is_opsz, is_lock, is_nop1, is_esc, is_mnop;
  logic reg_zero;
  logic [TAIL_W-1:0] tail;

  // named events for the assertions
  logic accept, finish, fin_nop, fin_fault, set_opsz, set_lock, load_tail;
  logic unsup_hit;

  nop_byte_class u_cls (
    .byte_in(in_data), .is_opsz(is_opsz), .is_lock(is_lock),
    .is_nop1(is_nop1), .is_esc(is_esc), .is_mnop(is_mnop)
  );

  nop_desc_decode u_desc (.desc(in_data), .reg_zero(reg_zero), .tail(tail));

  assign in_ready  = (state != S_DONE);
  assign accept    = in_valid && in_ready;
  assign cnt_inc   = cnt + 1'b1;
  assign unsup_hit = accept && state == S_ESC && is_mnop && !multibyte_en;

  always_comb begin
    nxt_state = state;
    finish    = 1'b0;
    fin_nop   = 1'b0;
    fin_fault = 1'b0;
    set_opsz  = 1'b0;
    set_lock  = 1'b0;
    load_tail = 1'b0;
    if (accept) begin
      unique case (state)
        S_PFX: begin
          if (is_opsz && !opsz_seen)      set_opsz = 1'b1;
          else if (is_lock && !lock_seen) set_lock = 1'b1;
          else if (is_nop1) begin
            finish = 1'b1; fin_nop = !lock_seen; fin_fault = lock_seen;
          end
          else if (is_esc) nxt_state = S_ESC;
          else finish = 1'b1;
        end
        S_ESC: begin
          if (is_mnop && multibyte_en) nxt_state = S_MODRM;
          else begin
            finish = 1'b1; fin_fault = is_mnop;
          end
        end
        S_MODRM: begin
          if (!reg_zero) finish = 1'b1;
          else if (tail == '0) begin
            finish = 1'b1; fin_nop = !lock_seen; fin_fault = lock_seen;
          end
          else begin
            nxt_state = S_TAIL; load_tail = 1'b1;
          end
        end
        S_TAIL: begin
          if (remain == TAIL_W'(1)) begin
            finish = 1'b1; fin_nop = !lock_seen; fin_fault = lock_seen;
          end
        end
        default: ;
      endcase
      if (finish) nxt_state = S_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_PFX;
      cnt        <= '0;
      remain     <= '0;
      opsz_seen  <= 1'b0;
      lock_seen  <= 1'b0;
      res_is_nop <= 1'b0;
      res_fault  <= 1'b0;
      res_len    <= '0;
    end else if (state == S_DONE) begin
      state     <= S_PFX;
      cnt       <= '0;
      remain    <= '0;
      opsz_seen <= 1'b0;
      lock_seen <= 1'b0;
    end else if (accept) begin
      state <= nxt_state;
      cnt   <= cnt_inc;
      if (set_opsz) opsz_seen <= 1'b1;
      if (set_lock) lock_seen <= 1'b1;
      if (load_tail) remain <= tail;
      else if (state == S_TAIL) remain <= remain - 1'b1;
      if (finish) begin
        res_is_nop <= fin_nop;
        res_fault  <= fin_fault;
        res_len    <= cnt_inc;
      end
    end
  end

  assign res_valid = (state == S_DONE);

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R2
  AST_BUSY_DURING_RESULT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !in_ready); // R2
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_len != '0 && res_len <= LEN_W'(MAX_LEN))); // R4
  AST_FAULT_NOT_NOP: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !(res_is_nop && res_fault)); // R8
  AST_UNSUP_FAULT: assert property (@(posedge clk) disable iff (rst)
    unsup_hit |=> (res_valid && res_fault && !res_is_nop)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !res_valid) |=> (cnt == $past(cnt))); // R11
  AST_FRESH_START: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (in_ready && cnt == '0 && !opsz_seen && !lock_seen)); // R12
endmodule

// File: tb/test_nop_len_decoder.sv
`timescale 1ns/1ps
module test_nop_len_decoder;
  logic       clk = 1'b0;
  logic       rst;
  logic       multibyte_en;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready, res_valid, res_is_nop, res_fault;
  logic [3:0] res_len;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  nop_len_decoder i_nop_len_decoder (
    .clk(clk), .rst(rst), .multibyte_en(multibyte_en),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .res_valid(res_valid), .res_is_nop(res_is_nop),
    .res_fault(res_fault), .res_len(res_len)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // seq holds n bytes, first byte in the most significant used position
  task automatic send(input logic [79:0] seq, input int n, input int gap, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = seq[8*(n-1-i) +: 8];
      @(posedge clk);
      if (i < n - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_data  = 8'h90;
          chk(res_valid == 1'b0, {tag, " R11 idle no result"}, res_valid, 0);
          @(posedge clk);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_res(input string tag, input bit nop, input bit flt, input int len);
    chk(res_valid == 1'b1, {tag, " valid"}, res_valid, 1);
    chk(res_is_nop == nop, {tag, " is_nop"}, res_is_nop, nop);
    chk(res_fault == flt, {tag, " fault"}, res_fault, flt);
    chk(res_len == len, {tag, " len"}, res_len, len);
    chk(in_ready == 1'b0, {tag, " R2 busy in pulse"}, in_ready, 0);
    @(negedge clk);
    chk(res_valid == 1'b0, {tag, " R2 one-cycle pulse"}, res_valid, 0);
    chk(in_ready == 1'b1, {tag, " R12 ready again"}, in_ready, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1; multibyte_en = 1'b1; in_valid = 1'b0; in_data = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(res_valid == 1'b0, "R1 reset valid", res_valid, 0);
    chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
  endtask

  task automatic t_one_byte();
    send(80'h90, 1, 0, "R2"); expect_res("R2 90", 1, 0, 1);
  endtask

  task automatic t_prefix();
    send(80'h6690, 2, 0, "R3"); expect_res("R3 66 90", 1, 0, 2);
  endtask

  task automatic t_recommended();
    send(80'h0F1F00, 3, 0, "R4"); expect_res("R4 len3", 1, 0, 3);
    send(80'h0F1F4000, 4, 0, "R4"); expect_res("R4 len4", 1, 0, 4);
    send(80'h0F1F440000, 5, 0, "R4"); expect_res("R4 len5", 1, 0, 5);
    send(80'h660F1F440000, 6, 0, "R4"); expect_res("R4 len6", 1, 0, 6);
    send(80'h0F1F8000000000, 7, 0, "R4"); expect_res("R4 len7", 1, 0, 7);
    send(80'h0F1F840000000000, 8, 0, "R4"); expect_res("R4 len8", 1, 0, 8);
    send(80'h660F1F840000000000, 9, 0, "R4"); expect_res("R4 len9", 1, 0, 9);
  endtask

  task automatic t_general_desc();
    send(80'h0F1FC0, 3, 0, "R5"); expect_res("R5 reg form", 1, 0, 3);
    send(80'h0F1F0511223344, 7, 0, "R5"); expect_res("R5 abs disp32", 1, 0, 7);
    send(80'h0F1F0400, 4, 0, "R5"); expect_res("R5 index only", 1, 0, 4);
    send(80'h0F1F4100, 4, 0, "R5"); expect_res("R5 disp8 rm1", 1, 0, 4);
  endtask

  task automatic t_bad_reg();
    send(80'h0F1F08, 3, 0, "R6"); expect_res("R6 reg1 mode0", 0, 0, 3);
    send(80'h660F1F48, 4, 0, "R6"); expect_res("R6 reg1 prefixed", 0, 0, 4);
  endtask

  task automatic t_foreign();
    send(80'h31, 1, 0, "R7"); expect_res("R7 foreign", 0, 0, 1);
    send(80'h6631, 2, 0, "R7"); expect_res("R7 prefixed foreign", 0, 0, 2);
    send(80'h0F05, 2, 0, "R7"); expect_res("R7 bad escape", 0, 0, 2);
  endtask

  task automatic t_lock();
    send(80'hF090, 2, 0, "R8"); expect_res("R8 lock 90", 0, 1, 2);
    send(80'hF00F1F4000, 5, 0, "R8"); expect_res("R8 lock multi", 0, 1, 5);
    send(80'hF0660F1F840000000000, 10, 0, "R8"); expect_res("R8 lock max", 0, 1, 10);
  endtask

  task automatic t_unsupported();
    multibyte_en = 1'b0;
    send(80'h0F1F, 2, 0, "R9"); expect_res("R9 unsup", 0, 1, 2);
    send(80'h660F1F, 3, 0, "R9"); expect_res("R9 unsup prefixed", 0, 1, 3);
    send(80'h90, 1, 0, "R9"); expect_res("R9 one-byte kept", 1, 0, 1);
    multibyte_en = 1'b1;
  endtask

  task automatic t_repeat_prefix();
    send(80'h6666, 2, 0, "R10"); expect_res("R10 66 66", 0, 0, 2);
    send(80'hF0F0, 2, 0, "R10"); expect_res("R10 F0 F0", 0, 0, 2);
  endtask

  task automatic t_gaps();
    send(80'h0F1F440000, 5, 3, "R11"); expect_res("R11 spaced len5", 1, 0, 5);
    send(80'h6690, 2, 2, "R11"); expect_res("R11 spaced 66 90", 1, 0, 2);
  endtask

  task automatic t_back_to_back();
    send(80'hF031, 2, 0, "R12"); expect_res("R12 first", 0, 0, 2);
    send(80'h90, 1, 0, "R12"); expect_res("R12 no lock carried", 1, 0, 1);
  endtask

  initial begin
    t_reset();
    t_one_byte();
    t_prefix();
    t_recommended();
    t_general_desc();
    t_bad_reg();
    t_foreign();
    t_lock();
    t_unsupported();
    t_repeat_prefix();
    t_gaps();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule